// File: doc/BRIEF.md
# I2C Controller Interrupt Aggregator

This block collects the eight event lines of an I2C controller into one interrupt request. Each event line sets its own sticky bit in a status register. An eight-bit enable register masks the status. A single global-enable bit then gates the masked result onto one interrupt output. Software reads the status, clears the bits it has serviced by writing ones to them, and can return the whole controller to its reset state by writing a key value to a reset register.

The block sits behind a plain register port: a byte offset, 32-bit write data, a write strobe and combinational read data. The event sources are outside the block. Some of them are one-cycle pulses (arbitration lost, transmit fault, addressed as slave, no longer addressed). Others are levels that stay high while their condition holds (TX FIFO empty, RX at threshold, bus idle, TX FIFO half empty). The block treats every line the same way: a high line sets its bit on the next clock edge.

Top module: `i2c_irq_unit`

## Requirements
- R1: Event line i sets status bit i on the next clock edge, and the bit stays set after the line drops. The bit positions are: 0 arbitration lost, 1 transmit fault or transfer complete, 2 TX FIFO empty, 3 RX at threshold, 4 bus idle, 5 addressed as slave, 6 no longer addressed, 7 TX FIFO half empty. The status reads at byte offset 0x20, in bits 7:0.
- R2: A write to offset 0x20 clears every status bit whose write-data bit is 1. Bits written with 0 keep their value.
- R3: If an event line is high in the same cycle as a write that clears its bit, the bit stays set. A level source that is still active therefore shows again at once.
- R4: The enable mask is read and written at offset 0x28, in bits 7:0. The upper bits read as zero.
- R5: The global enable is bit 31 of offset 0x1C. The other bits of that word ignore writes and read as zero.
- R6: irq_o is high exactly when the global enable is 1 and at least one bit is set in both status and enable.
- R7: Writing exactly 0x0000000A to offset 0x40 drives soft_rst_o high for the one cycle after the write edge. Any other value written there produces no pulse and changes no register.
- R8: A key write to offset 0x40 clears status, enable and global enable to zero at the write edge.
- R9: Offset 0x40 and every unmapped offset read as zero.
- R10: After a synchronous active-low reset, status, enable, global enable, irq_o and soft_rst_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | ADDR_W (8) | Byte offset of the register access |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_wr | input | 1 | Write strobe, one write per high cycle |
| reg_rdata | output | DATA_W (32) | Combinational read data for reg_addr |
| evt_i | input | 8 | Event lines, one per status bit |
| irq_o | output | 1 | Gated interrupt request |
| soft_rst_o | output | 1 | One-cycle controller reset pulse |

## Verification
The bench targets the same-cycle collision between an event and its own clear. It does this once with a level source held high and once with a one-cycle pulse. A design that let the clear win would drop a pending interrupt and miss the event. It also writes a near-miss value to the reset register and then checks that no pulse appears and the mask and global enable keep their values. A loose key compare would show up there as a spurious controller reset. Finally, it writes all ones to the global-enable word and to the enable word. A design that stored or echoed the unused bits would fail these readback checks, and the irq_o checks run with each gate open and closed in turn.

// File: rtl/i2c_irq_pkg.sv
// Package: shared constants and types for the I2C interrupt aggregator.
// Assumes byte offsets on the register port and 32-bit data words.
package i2c_irq_pkg;

    localparam int unsigned NUM_EVT = 8;

    // Bit positions of the event sources within the status word
    typedef enum int unsigned {
        EV_ARB_LOST  = 0,
        EV_TX_FAULT  = 1,
        EV_TX_EMPTY  = 2,
        EV_RX_LEVEL  = 3,
        EV_BUS_IDLE  = 4,
        EV_ADDR_HIT  = 5,
        EV_ADDR_MISS = 6,
        EV_TX_HALF   = 7
    } evt_idx_e;

    localparam int unsigned OFS_GIE   = 'h1C;
    localparam int unsigned OFS_STAT  = 'h20;
    localparam int unsigned OFS_EN    = 'h28;
    localparam int unsigned OFS_RESET = 'h40;

    localparam int unsigned RESET_KEY = 'hA;

    // One select line per mapped register
    typedef struct packed {
        logic gie;
        logic stat;
        logic en;
        logic rst;
    } reg_sel_t;

endpackage

// File: rtl/irq_addr_decode.sv
// Module: decodes the byte offset into one select per register.
// Assumes full-offset compare; unmapped offsets select nothing.
module irq_addr_decode
    import i2c_irq_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    output reg_sel_t          rsel_o,
    output reg_sel_t          wsel_o
);

    // Purpose: compare the offset against each mapped register
    always_comb begin
        rsel_o.gie  = (addr_i == ADDR_W'(OFS_GIE));
        rsel_o.stat = (addr_i == ADDR_W'(OFS_STAT));
        rsel_o.en   = (addr_i == ADDR_W'(OFS_EN));
        rsel_o.rst  = (addr_i == ADDR_W'(OFS_RESET));
    end

    // Purpose: qualify the selects with the write strobe
    always_comb begin
        wsel_o.gie  = rsel_o.gie  & wr_i;
        wsel_o.stat = rsel_o.stat & wr_i;
        wsel_o.en   = rsel_o.en   & wr_i;
        wsel_o.rst  = rsel_o.rst  & wr_i;
    end

endmodule

// File: rtl/irq_status_bank.sv
// Module: sticky status bits with write-one-to-clear.
// Assumes event lines are synchronous to clk. A set from an event wins over
// a clear in the same cycle; clr_all (soft reset) wins over both.
module irq_status_bank #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_all,
    input  logic [N-1:0] evt_i,
    input  logic         w1c_en,
    input  logic [N-1:0] w1c_mask,
    output logic [N-1:0] status_o
);

    logic [N-1:0] status_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        // Purpose: hold, set or clear one status bit
        always_ff @(posedge clk) begin
            if (!rst_n || clr_all)
                status_q[i] <= 1'b0;
            else if (evt_i[i])
                status_q[i] <= 1'b1;
            else if (w1c_en && w1c_mask[i])
                status_q[i] <= 1'b0;
        end
    end

    assign status_o = status_q;

    // R1: a newly set bit always has an event behind it
    a_r1_set_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & ~$past(status_q) & ~$past(evt_i)) == '0));

    // R2: a clear with no competing event leaves the bit at zero
    a_r2_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (w1c_en && !clr_all) |=> ((status_q & $past(w1c_mask & ~evt_i)) == '0));

    // R3: an event is never lost, even when a clear hits the same bit
    a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_all |=> ((status_q & $past(evt_i)) == $past(evt_i)));

endmodule

// File: rtl/irq_ctrl_regs.sv
// Module: enable mask, global enable and the key-protected soft reset.
// Assumes one write per strobe cycle. The key write clears the registers at
// its edge and raises the reset pulse for the following cycle.
module irq_ctrl_regs #(
    parameter int unsigned N      = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned KEY    = 'hA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_gie,
    input  logic              wr_en,
    input  logic              wr_rst,
    input  logic [DATA_W-1:0] wdata,
    output logic [N-1:0]      en_o,
    output logic              gie_o,
    output logic              key_hit_o,
    output logic              soft_rst_o
);

    localparam int unsigned GIE_BIT = DATA_W - 1;

    logic [N-1:0] en_q;
    logic         gie_q;
    logic         pulse_q;

    // Purpose: exact key match on a write to the reset register
    assign key_hit_o = wr_rst && (wdata == DATA_W'(KEY));

    // Purpose: enable mask storage
    always_ff @(posedge clk) begin
        if (!rst_n || key_hit_o)
            en_q <= '0;
        else if (wr_en)
            en_q <= wdata[N-1:0];
    end

    // Purpose: global enable storage, top data bit only
    always_ff @(posedge clk) begin
        if (!rst_n || key_hit_o)
            gie_q <= 1'b0;
        else if (wr_gie)
            gie_q <= wdata[GIE_BIT];
    end

    // Purpose: one-cycle soft reset pulse
    always_ff @(posedge clk) begin
        if (!rst_n)
            pulse_q <= 1'b0;
        else
            pulse_q <= key_hit_o;
    end

    assign en_o       = en_q;
    assign gie_o      = gie_q;
    assign soft_rst_o = pulse_q;

    // R7: a pulse only ever follows an exact key write
    a_r7_pulse_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |-> $past(wr_rst && (wdata == DATA_W'(KEY))));

    // R8: during the pulse the control registers are already cleared
    a_r8_regs_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |-> (en_q == '0 && !gie_q));

endmodule

// File: rtl/i2c_irq_unit.sv
// Module: top of the I2C interrupt aggregator. It wires decode, status bank
// and control registers, forms the read data and gates the interrupt output.
// Assumes synchronous active-low reset and combinational reads.
module i2c_irq_unit
    import i2c_irq_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    input  logic                reg_wr,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic [NUM_EVT-1:0]  evt_i,
    output logic                irq_o,
    output logic                soft_rst_o
);

    localparam int unsigned GIE_BIT = DATA_W - 1;

    reg_sel_t           rsel;
    reg_sel_t           wsel;
    logic [NUM_EVT-1:0] status;
    logic [NUM_EVT-1:0] en_mask;
    logic               gie;
    logic               key_hit;

    irq_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr_i (reg_addr),
        .wr_i   (reg_wr),
        .rsel_o (rsel),
        .wsel_o (wsel)
    );

    irq_ctrl_regs #(.N(NUM_EVT), .DATA_W(DATA_W), .KEY(RESET_KEY)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_gie     (wsel.gie),
        .wr_en      (wsel.en),
        .wr_rst     (wsel.rst),
        .wdata      (reg_wdata),
        .en_o       (en_mask),
        .gie_o      (gie),
        .key_hit_o  (key_hit),
        .soft_rst_o (soft_rst_o)
    );

    irq_status_bank #(.N(NUM_EVT)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_all  (key_hit),
        .evt_i    (evt_i),
        .w1c_en   (wsel.stat),
        .w1c_mask (reg_wdata[NUM_EVT-1:0]),
        .status_o (status)
    );

    // Purpose: read data multiplexer; reset register and holes read zero
    always_comb begin
        reg_rdata = '0;
        if (rsel.gie)
            reg_rdata[GIE_BIT] = gie;
        else if (rsel.stat)
            reg_rdata[NUM_EVT-1:0] = status;
        else if (rsel.en)
            reg_rdata[NUM_EVT-1:0] = en_mask;
    end

    // Purpose: masked, globally gated interrupt request
    assign irq_o = gie && (|(status & en_mask));

    // R6: the request never appears while the global gate is closed
    a_r6_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |-> !irq_o);

    // R10: after reset the outputs are quiet
    a_r10_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (!irq_o && !soft_rst_o));

endmodule

// File: tb/i2c_irq_unit_tb_top.sv
module i2c_irq_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_rdata;
    logic [7:0]  evt_i = '0;
    logic        irq_o;
    logic        soft_rst_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    i2c_irq_unit dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_wr     (reg_wr),
        .reg_rdata  (reg_rdata),
        .evt_i      (evt_i),
        .irq_o      (irq_o),
        .soft_rst_o (soft_rst_o)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    // write on one edge; returns at the following falling edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse_evt(input logic [7:0] e);
        evt_i = e;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(8'h20, d); chk("R10 status", d, 32'h0);
        rd(8'h28, d); chk("R10 enable", d, 32'h0);
        rd(8'h1C, d); chk("R10 gie", d, 32'h0);
        chk("R10 irq", {31'b0, irq_o}, 32'h0);
        chk("R10 softrst", {31'b0, soft_rst_o}, 32'h0);
    endtask

    task automatic t_latch;
        logic [31:0] d;
        pulse_evt(8'h01);
        rd(8'h20, d); chk("R1 arb lost bit0", d, 32'h01);
        pulse_evt(8'h20);
        @(negedge clk);
        rd(8'h20, d); chk("R1 sticky bits 0 and 5", d, 32'h21);
    endtask

    task automatic t_w1c;
        logic [31:0] d;
        pulse_evt(8'h80);
        wr(8'h20, 32'h0000_0001);
        rd(8'h20, d); chk("R2 clear bit0 only", d, 32'hA0);
        wr(8'h20, 32'h0);
        rd(8'h20, d); chk("R2 zero write no effect", d, 32'hA0);
        wr(8'h20, 32'hFFFF_FFFF);
        rd(8'h20, d); chk("R2 clear all", d, 32'h0);
    endtask

    task automatic t_collide;
        logic [31:0] d;
        evt_i = 8'h04;
        @(negedge clk);
        wr(8'h20, 32'h04);
        rd(8'h20, d); chk("R3 level held over clear", d, 32'h04);
        evt_i = 8'h00;
        wr(8'h20, 32'h04);
        rd(8'h20, d); chk("R3 cleared after level drops", d, 32'h0);
        pulse_evt(8'h02);
        evt_i = 8'h02;
        wr(8'h20, 32'h02);
        evt_i = 8'h00;
        rd(8'h20, d); chk("R3 pulse wins same-cycle clear", d, 32'h02);
        wr(8'h20, 32'hFF);
    endtask

    task automatic t_enable_gie;
        logic [31:0] d;
        wr(8'h28, 32'hFFFF_FF5A);
        rd(8'h28, d); chk("R4 enable readback", d, 32'h5A);
        wr(8'h1C, 32'hFFFF_FFFF);
        rd(8'h1C, d); chk("R5 gie only bit31", d, 32'h8000_0000);
        wr(8'h1C, 32'h7FFF_FFFF);
        rd(8'h1C, d); chk("R5 gie cleared by bit31=0", d, 32'h0);
    endtask

    task automatic t_irq;
        pulse_evt(8'h01);
        chk("R6 gie off no irq", {31'b0, irq_o}, 32'h0);
        wr(8'h1C, 32'h8000_0000);
        chk("R6 masked bit0 no irq", {31'b0, irq_o}, 32'h0);
        pulse_evt(8'h02);
        chk("R6 enabled bit1 irq", {31'b0, irq_o}, 32'h1);
        wr(8'h1C, 32'h0);
        chk("R6 gie off drops irq", {31'b0, irq_o}, 32'h0);
        wr(8'h1C, 32'h8000_0000);
        wr(8'h20, 32'h02);
        chk("R6 clear drops irq", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_soft_reset;
        logic [31:0] d;
        pulse_evt(8'h10);
        wr(8'h40, 32'h0000_000B);
        chk("R7 non-key no pulse", {31'b0, soft_rst_o}, 32'h0);
        rd(8'h28, d); chk("R7 non-key keeps enable", d, 32'h5A);
        rd(8'h1C, d); chk("R7 non-key keeps gie", d, 32'h8000_0000);
        rd(8'h20, d); chk("R7 non-key keeps status", d, 32'h11);
        wr(8'h40, 32'h1000_000A);
        chk("R7 high bits spoil key", {31'b0, soft_rst_o}, 32'h0);
        wr(8'h40, 32'h0000_000A);
        chk("R7 key pulse high", {31'b0, soft_rst_o}, 32'h1);
        rd(8'h20, d); chk("R8 status cleared", d, 32'h0);
        rd(8'h28, d); chk("R8 enable cleared", d, 32'h0);
        rd(8'h1C, d); chk("R8 gie cleared", d, 32'h0);
        @(negedge clk);
        chk("R7 pulse one cycle", {31'b0, soft_rst_o}, 32'h0);
    endtask

    task automatic t_holes;
        logic [31:0] d;
        wr(8'h28, 32'hFF);
        rd(8'h40, d); chk("R9 reset reg reads zero", d, 32'h0);
        rd(8'h24, d); chk("R9 hole 0x24 zero", d, 32'h0);
        rd(8'h29, d); chk("R9 hole 0x29 zero", d, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_latch();
        t_w1c();
        t_collide();
        t_enable_gie();
        wr(8'h28, 32'h5A);
        t_irq();
        t_soft_reset();
        t_holes();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule